// File: doc/BRIEF.md
# Dual-Read Single-Write Register File with Null Identifier

This block stores the eight 32-bit general-purpose registers of a small integer processor core. Two read ports and one write port each carry their own 4-bit register identifier and 32-bit data lines. Both read ports are purely combinational: each data output follows its identifier with no clock involved. The write port changes the addressed register only on the rising clock edge. The processor's condition flags, program counter, data memory and any operand forwarding sit outside this block.

Identifiers 0 to 7 select registers 0 to 7, one to one. Every other identifier, 8 through 15, selects no register. The core's decoder normally uses 15 (0xF) for "no operand". A read port given such an identifier returns zero. A write port given one leaves every register untouched, so the core can keep the write port idle without a separate enable.

A read and a write to the same register in the same cycle do not bypass: the read port returns the old value until the clock edge. An active-high synchronous reset clears all eight registers. The storage is plain state, not a stream, so the ports carry no valid/ready handshake and never stall.

Top module: `gpr_file`

## Requirements
- R1: While `rst` is high at a rising clock edge, all eight registers become zero, and a write presented in that same cycle is lost. After reset, every read of identifiers 0 to 7 returns 0x00000000.
- R2: With `dst_w_id` set to a value k from 0 to 7, the register k takes `dst_w_data` at the rising clock edge. From then on, reads of identifier k return that value.
- R3: The read ports are combinational. When a read identifier changes while the clock is held steady, the matching data output shows the newly selected register within the same clock phase.
- R4: The two read ports are independent. Different identifiers on `src_a_id` and `src_b_id` return their own registers in the same cycle, and equal identifiers return the same value on both ports.
- R5: A read port given identifier 0xF drives 0x00000000 on its data output, whatever the registers hold.
- R6: A write with `dst_w_id` = 0xF changes no register.
- R7: Identifiers 8 through 14 behave like 0xF. A read of one of them returns 0x00000000, and a write to one of them changes no register.
- R8: During a cycle in which register k is being written, a read of identifier k returns the value k held before that cycle's rising edge. The new value appears only after the edge.
- R9: Each identifier 0 to 7 reaches its own separate register. A write to identifier k leaves the other seven registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset take effect on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears all registers |
| src_a_id | input | 4 | Register identifier for read port A (8 to 15 = none) |
| src_a_data | output | 32 | Contents of the register selected by `src_a_id`, or zero |
| src_b_id | input | 4 | Register identifier for read port B (8 to 15 = none) |
| src_b_data | output | 32 | Contents of the register selected by `src_b_id`, or zero |
| dst_w_id | input | 4 | Register identifier for the write port (8 to 15 = no write) |
| dst_w_data | input | 32 | Value written to the register selected by `dst_w_id` |

## Verification
Each register gets a distinct value: walking ones, all ones and alternating bit patterns. This separates a correct identifier-to-register mapping from aliasing, and it catches stuck data bits. Paired reads with unequal and then equal identifiers show that the two read ports decode separately. Each write is read back on its own identifier in the same low clock phase, then again after the edge, which tells the old-value-until-the-edge behaviour apart from a bypass or a late update. Writes to 0xF and to 8 through 14 are followed by a full readback of all registers, and reads of those identifiers are made while every register is non-zero. A reset asserted together with a pending write shows that the reset takes priority.

// File: rtl/gpr_file_pkg.sv
package gpr_file_pkg;
  // Shared sizing for the register file
  localparam int unsigned GPR_COUNT   = 8;
  localparam int unsigned GPR_WIDTH   = 32;
  localparam int unsigned GPR_ID_BITS = 4;
  // Identifier the instruction decoder uses for "no operand"
  localparam logic [GPR_ID_BITS-1:0] GPR_NONE = '1;
endpackage

// File: rtl/rf_id_decode.sv
// Turns a register identifier into a one-hot register select.
// Identifiers at or above NUM_REGS select nothing.
module rf_id_decode #(
  parameter int unsigned ID_W     = 4,
  parameter int unsigned NUM_REGS = 8
) (
  input  logic [ID_W-1:0]     id,
  output logic [NUM_REGS-1:0] sel,
  output logic                hit
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_match
    assign sel[g] = (id == ID_W'(g));
  end
  assign hit = |sel;
endmodule

// File: rtl/rf_storage.sv
// Register array: synchronous clear, one write per edge through a one-hot select.
module rf_storage #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [NUM_REGS-1:0]              wr_sel,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (wr_en && wr_sel[g]) begin
        regs_q[g] <= wr_data;
      end
    end
  end

  // R9: the decoder never selects more than one register
  a_r9_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));
endmodule

// File: rtl/rf_read_mux.sv
// AND-OR selection of one register; zero when no register is selected.
module rf_read_mux #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic [NUM_REGS-1:0]              sel,
  input  logic                             hit,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
  output logic [DATA_W-1:0]                data
);
  logic [DATA_W-1:0] merged;

  always_comb begin
    merged = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      merged = merged | ({DATA_W{sel[i]}} & regs[i]);
    end
  end

  assign data = hit ? merged : '0;
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_file_pkg::*;
#(
  parameter int unsigned NUM_REGS = GPR_COUNT,
  parameter int unsigned DATA_W   = GPR_WIDTH,
  parameter int unsigned ID_W     = GPR_ID_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   src_a_id,
  output logic [DATA_W-1:0] src_a_data,
  input  logic [ID_W-1:0]   src_b_id,
  output logic [DATA_W-1:0] src_b_data,
  input  logic [ID_W-1:0]   dst_w_id,
  input  logic [DATA_W-1:0] dst_w_data
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);
  localparam logic [ID_W-1:0] FIRST_NULL = ID_W'(NUM_REGS);

  logic [NUM_REGS-1:0]             a_sel, b_sel, w_sel;
  logic                            a_hit, b_hit, w_hit;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  rf_id_decode #(.ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_dec_a (
    .id(src_a_id), .sel(a_sel), .hit(a_hit));
  rf_id_decode #(.ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_dec_b (
    .id(src_b_id), .sel(b_sel), .hit(b_hit));
  rf_id_decode #(.ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_dec_w (
    .id(dst_w_id), .sel(w_sel), .hit(w_hit));

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(w_hit), .wr_sel(w_sel),
    .wr_data(dst_w_data), .regs_q(regs_q));

  rf_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_mux_a (
    .sel(a_sel), .hit(a_hit), .regs(regs_q), .data(src_a_data));
  rf_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_mux_b (
    .sel(b_sel), .hit(b_hit), .regs(regs_q), .data(src_b_data));

  // R1: a reset edge leaves every register cleared
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (regs_q == '0));

  // R2: a write to a real register lands at the next edge
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (dst_w_id < FIRST_NULL) |=>
      (regs_q[$past(dst_w_id[IDX_W-1:0])] == $past(dst_w_data)));

  // R6 and R7: a write to an identifier without a register changes nothing
  a_r6_null_write_holds: assert property (@(posedge clk) disable iff (rst)
    (dst_w_id >= FIRST_NULL) |=> $stable(regs_q));

  // R5 and R7: a read without a register returns zero on either port
  a_r5_null_read_zero: assert property (@(posedge clk) disable iff (rst)
    ((src_a_id >= FIRST_NULL) |-> (src_a_data == '0)) and
    ((src_b_id >= FIRST_NULL) |-> (src_b_data == '0)));

  // R4: each read port shows the register its own identifier selects
  a_r4_ports_track_storage: assert property (@(posedge clk) disable iff (rst)
    ((src_a_id < FIRST_NULL) |-> (src_a_data == regs_q[src_a_id[IDX_W-1:0]])) and
    ((src_b_id < FIRST_NULL) |-> (src_b_data == regs_q[src_b_id[IDX_W-1:0]])));
endmodule

// File: tb/gpr_file_test.sv
`timescale 1ns/1ps
module gpr_file_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  src_a_id = 4'hF, src_b_id = 4'hF, dst_w_id = 4'hF;
  logic [31:0] dst_w_data = '0;
  logic [31:0] src_a_data, src_b_data;

  always #2.5 clk = ~clk;

  gpr_file uut (
    .clk(clk), .rst(rst),
    .src_a_id(src_a_id), .src_a_data(src_a_data),
    .src_b_id(src_b_id), .src_b_data(src_b_data),
    .dst_w_id(dst_w_id), .dst_w_data(dst_w_data));

  typedef struct {
    logic [3:0]  ida;
    logic [3:0]  idb;
    logic [31:0] ea;
    logic [31:0] eb;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  event        sample_ev;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          finished = 0;
  logic [31:0] model [8];

  // Monitor: pops the oldest expectation and compares both read ports
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (src_a_data !== e.ea || src_b_data !== e.eb) begin
          n_fail++;
          $display("FAIL %s: ids A=%0h B=%0h got A=%h B=%h expected A=%h B=%h",
                   e.tag, e.ida, e.idb, src_a_data, src_b_data, e.ea, e.eb);
        end
      end
    end
  end

  function automatic logic [31:0] expect_of(input logic [3:0] id);
    return (id < 4'd8) ? model[id[2:0]] : 32'h0;
  endfunction

  // Driver: apply read identifiers, let them settle, queue the expectation
  task automatic read_now(input logic [3:0] a, input logic [3:0] b,
                          input logic [31:0] ea, input logic [31:0] eb,
                          input string tag);
    exp_t e;
    src_a_id = a;
    src_b_id = b;
    #0.4;
    e.ida = a; e.idb = b; e.ea = ea; e.eb = eb; e.tag = tag;
    sb_q.push_back(e);
    -> sample_ev;
    #0.1;
  endtask

  task automatic read_model(input logic [3:0] a, input logic [3:0] b,
                            input string tag);
    @(negedge clk);
    read_now(a, b, expect_of(a), expect_of(b), tag);
  endtask

  task automatic read_all(input string tag);
    for (int k = 0; k < 8; k += 2) begin
      read_model(4'(k), 4'(k + 1), tag);
    end
  endtask

  // Write one register; during the write cycle, read it back to check R8
  task automatic write_reg(input logic [3:0] id, input logic [31:0] val);
    @(negedge clk);
    dst_w_id   = id;
    dst_w_data = val;
    read_now(id, id, expect_of(id), expect_of(id), "R8");
    @(posedge clk);
    #0.2;
    dst_w_id = 4'hF;
    if (id < 4'd8) model[id[2:0]] = val;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) model[k] = 32'h0;
    repeat (3) @(posedge clk);
    #0.2 rst = 1'b0;

    // R1: all registers clear after reset
    read_all("R1");

    // R2, R8, R9: distinct patterns into each register
    write_reg(4'd0, 32'h0000_0001);
    write_reg(4'd1, 32'h0000_0100);
    write_reg(4'd2, 32'h0001_0000);
    write_reg(4'd3, 32'h8000_0000);
    write_reg(4'd4, 32'hFFFF_FFFF);
    write_reg(4'd5, 32'hAAAA_5555);
    write_reg(4'd6, 32'h5555_AAAA);
    write_reg(4'd7, 32'h1234_ABCD);
    read_all("R2");
    read_all("R9");

    // R9: overwrite one register, others unchanged
    write_reg(4'd4, 32'h0BAD_F00D);
    read_all("R9");

    // R4: independent ports, crossed and equal identifiers
    read_model(4'd7, 4'd0, "R4");
    read_model(4'd3, 4'd5, "R4");
    read_model(4'd6, 4'd6, "R4");

    // R3: identifiers change twice within one low phase, no clock edge
    @(negedge clk);
    read_now(4'd1, 4'd2, expect_of(4'd1), expect_of(4'd2), "R3");
    read_now(4'd5, 4'd7, expect_of(4'd5), expect_of(4'd7), "R3");
    read_now(4'd0, 4'd4, expect_of(4'd0), expect_of(4'd4), "R3");

    // R5: 0xF reads zero while every register is non-zero
    read_model(4'hF, 4'd4, "R5");
    read_model(4'd2, 4'hF, "R5");
    read_model(4'hF, 4'hF, "R5");

    // R7: identifiers 8..14 read zero
    for (int k = 8; k < 15; k++) begin
      read_model(4'(k), 4'(22 - k), "R7");
    end

    // R6: a write to 0xF changes nothing
    write_reg(4'hF, 32'hDEAD_BEEF);
    read_all("R6");

    // R7: writes to 8..14 change nothing
    for (int k = 8; k < 15; k++) begin
      write_reg(4'(k), 32'hC0DE_0000 | 32'(k));
    end
    read_all("R7");

    // R8: back-to-back writes to the same register
    write_reg(4'd2, 32'h0000_0022);
    write_reg(4'd2, 32'h0000_0033);
    read_model(4'd2, 4'd1, "R8");

    // R1: reset wins over a write in the same cycle
    @(negedge clk);
    rst        = 1'b1;
    dst_w_id   = 4'd3;
    dst_w_data = 32'h7777_7777;
    @(posedge clk);
    #0.2;
    rst      = 1'b0;
    dst_w_id = 4'hF;
    for (int k = 0; k < 8; k++) model[k] = 32'h0;
    read_all("R1");

    // R2: write after reset
    write_reg(4'd6, 32'h6666_0006);
    read_model(4'd6, 4'd5, "R2");

    @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule